// File: doc/BRIEF.md
# Flash Page Programmer with Completion Polling

This block runs on the programming host. It writes one page of on-chip flash through a four-byte serial instruction shifter. The shifter is assumed to be in sync with the target already. After a start pulse the block walks a local page buffer one word at a time. Every word that is not fully erased gets two byte-load instructions, low byte first and then high byte. The block then commits the page with a single page-write instruction, and after that it waits until the write has finished.

The wait picks its method by itself. The block polls the low byte of the first word it loaded. While the write is running the target returns 0xFF for every address in the page, so a poll read that returns the loaded value marks completion. If that byte is itself 0xFF, polling cannot tell the difference, and the block waits a fixed number of cycles instead. The same cycle count also bounds the polling loop. When the count runs out before a poll matches, the block reports an error. A page whose words are all 0xFFFF needs no instruction at all, so the block only signals completion.

The controller is built around the states `ST_IDLE`, `ST_FETCH`, `ST_EXAM`, `ST_LO_REQ`, `ST_LO_RSP`, `ST_HI_REQ`, `ST_HI_RSP`, `ST_WR_REQ`, `ST_WR_RSP`, `ST_HOLD`, `ST_RD_REQ`, `ST_RD_RSP` and `ST_FINISH`. Their transitions are:

- `ST_IDLE` goes to `ST_FETCH` on start.
- `ST_FETCH` always goes to `ST_EXAM`.
- `ST_EXAM` goes to `ST_LO_REQ` for a word that is not fully erased.
- For an erased word, `ST_EXAM` goes back to `ST_FETCH` if more words follow. After the last word it goes to `ST_WR_REQ` if anything was loaded, and to `ST_FINISH` if nothing was.
- Each `*_REQ` state goes to its `*_RSP` state once the shifter accepts the instruction.
- `ST_LO_RSP` goes to `ST_HI_REQ` on the response.
- `ST_HI_RSP` goes to `ST_FETCH` on the response, or to `ST_WR_REQ` after the last word.
- `ST_WR_RSP` goes to `ST_HOLD` if the poll byte is 0xFF, and to `ST_RD_REQ` otherwise.
- `ST_HOLD` goes to `ST_FINISH` when the timer expires.
- `ST_RD_RSP` goes to `ST_FINISH` on a match or on timer expiry, and back to `ST_RD_REQ` otherwise.
- `ST_FINISH` returns to `ST_IDLE`.

Top module: `flash_page_prog`

## Requirements
- R1: While in reset and directly after it, `busy`, `done`, `err`, `req_valid` and `buf_rd` are all 0.
- R2: `start` is taken only while idle, and `busy` is 1 from the following cycle onward. A `start` pulse that arrives during a run is ignored, so only one page-write instruction is issued for that run.
- R3: Each word that is not 0xFFFF is loaded in ascending word order with two instructions, the low byte before the high byte. Each instruction is {opcode, 0x00, word index in the low IDX_W bits of byte 2 with zeros above, data byte}. The opcode is 0x40 for the low byte and 0x48 for the high byte.
- R4: Words equal to 0xFFFF produce no instruction. If every word is 0xFFFF, no instruction at all is issued, `done` pulses with `err` at 0, and the run takes no more than 2 cycles per word plus 8.
- R5: After the last load, one page-write instruction {0x4C, word address high byte, word address low byte, 0x00} is issued. The word address is {page_num, IDX_W zero bits}, right-aligned in 16 bits.
- R6: If the low byte of the first loaded word is not 0xFF, the block issues poll reads {0x20, address high, address low, 0x00} for that word's full address. It repeats the read until `rsp_byte` equals that byte, and then pulses `done` with `err` at 0.
- R7: If the low byte of the first loaded word is 0xFF, the block issues no poll reads. `done` then follows the page-write response after no fewer than WAIT_CYCLES and no more than WAIT_CYCLES+4 cycles.
- R8: If polling has not matched by the time WAIT_CYCLES cycles have passed since the page-write response, `done` pulses with `err` at 1. `err` holds until the next accepted `start`, which clears it.
- R9: From the page-write instruction until `done`, the only instructions issued are poll reads.
- R10: `req_cmd` and `req_valid` stay stable while `req_ready` is 0. At most one instruction is outstanding: no new request is raised until `rsp_valid` has returned for the previous one.
- R11: `done` is a single-cycle pulse, and `busy` is 0 while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin programming the page held in the buffer |
| page_num | input | PAGE_W | Page number, forms the upper word-address bits |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Polling timed out on the last run |
| buf_rd | output | 1 | Buffer read strobe |
| buf_idx | output | IDX_W | Buffer word index being read |
| buf_word | input | 16 | Buffer word, valid one cycle after `buf_rd` |
| req_valid | output | 1 | Instruction request to the shifter |
| req_ready | input | 1 | Shifter accepts the request |
| req_cmd | output | 32 | Four-byte instruction, first byte in bits 31:24 |
| rsp_valid | input | 1 | Shifter finished the instruction |
| rsp_byte | input | 8 | Byte shifted in during the fourth instruction byte |

## Verification
The checker watches every cycle at the shifter and status ports. It checks the request handshake and the single-outstanding rule, that each high-byte load pairs with the preceding low-byte load, and that load addresses have their upper bits cleared. It also checks that only poll reads follow the page write, that `done` is a one-cycle pulse, and that `err` rises only together with `done`. Other properties need a whole run to judge. These are the exact instruction sequence for a given page image, the skipping of erased words, the choice between polling and the timed wait, the length of that wait, the timeout error and its clearing, and the rejection of a second start. The bench's scenarios cover these against a model of the target flash.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

    // Instruction opcodes (first byte of each four-byte instruction)
    localparam logic [7:0] OP_LD_LO   = 8'h40;
    localparam logic [7:0] OP_LD_HI   = 8'h48;
    localparam logic [7:0] OP_WR_PAGE = 8'h4C;
    localparam logic [7:0] OP_RD_LO   = 8'h20;

    localparam logic [15:0] ERASED_WORD = 16'hFFFF;
    localparam logic [7:0]  ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        K_LD_LO,
        K_LD_HI,
        K_WR,
        K_RD
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXAM,
        ST_LO_REQ,
        ST_LO_RSP,
        ST_HI_REQ,
        ST_HI_RSP,
        ST_WR_REQ,
        ST_WR_RSP,
        ST_HOLD,
        ST_RD_REQ,
        ST_RD_RSP,
        ST_FINISH
    } prog_state_e;

endpackage

// File: rtl/fpp_cmd_build.sv
module fpp_cmd_build
    import fpp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int PAGE_W = 7
) (
    input  cmd_kind_e         kind,
    input  logic [PAGE_W-1:0] page,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        data,
    output logic [31:0]       cmd
);
    localparam int ADDR_W = PAGE_W + IDX_W;

    logic [15:0] addr;
    logic [7:0]  op;
    logic [7:0]  payload;

    always_comb begin
        addr    = '0;
        op      = OP_LD_LO;
        payload = data;
        unique case (kind)
            K_LD_LO: begin
                op               = OP_LD_LO;
                addr[IDX_W-1:0]  = idx;
            end
            K_LD_HI: begin
                op               = OP_LD_HI;
                addr[IDX_W-1:0]  = idx;
            end
            K_WR: begin
                op                    = OP_WR_PAGE;
                addr[ADDR_W-1:IDX_W]  = page;
                payload               = '0;
            end
            K_RD: begin
                op                = OP_RD_LO;
                addr[ADDR_W-1:0]  = {page, idx};
                payload           = '0;
            end
            default: ;
        endcase
        cmd = {op, addr, payload};
    end

endmodule

// File: rtl/fpp_wait_timer.sv
module fpp_wait_timer #(
    parameter int LIMIT = 4500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != CW'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT));

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
    import fpp_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int PAGE_W      = 7,
    parameter int WAIT_CYCLES = 4500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_num,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              buf_rd,
    output logic [IDX_W-1:0]  buf_idx,
    input  logic [15:0]       buf_word,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [31:0]       req_cmd,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_byte
);
    localparam int PAGE_WORDS = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_WORDS - 1);

    prog_state_e       st, nxt;
    logic [IDX_W-1:0]  idx;
    logic [15:0]       word_q;
    logic [PAGE_W-1:0] page_q;
    logic              found;
    logic [IDX_W-1:0]  poll_idx;
    logic [7:0]        poll_val;
    logic              last;
    logic              expired;
    logic              timer_clr;
    cmd_kind_e         kind;
    logic [IDX_W-1:0]  cmd_idx;
    logic [7:0]        cmd_data;

    assign last = (idx == LAST_IDX);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   if (start) nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_EXAM;
            ST_EXAM: begin
                if (buf_word != ERASED_WORD) nxt = ST_LO_REQ;
                else if (!last)              nxt = ST_FETCH;
                else if (found)              nxt = ST_WR_REQ;
                else                         nxt = ST_FINISH;
            end
            ST_LO_REQ: if (req_ready) nxt = ST_LO_RSP;
            ST_LO_RSP: if (rsp_valid) nxt = ST_HI_REQ;
            ST_HI_REQ: if (req_ready) nxt = ST_HI_RSP;
            ST_HI_RSP: if (rsp_valid) nxt = last ? ST_WR_REQ : ST_FETCH;
            ST_WR_REQ: if (req_ready) nxt = ST_WR_RSP;
            ST_WR_RSP: if (rsp_valid) nxt = (poll_val == ERASED_BYTE) ? ST_HOLD : ST_RD_REQ;
            ST_HOLD:   if (expired) nxt = ST_FINISH;
            ST_RD_REQ: if (req_ready) nxt = ST_RD_RSP;
            ST_RD_RSP: if (rsp_valid)
                           nxt = (rsp_byte == poll_val || expired) ? ST_FINISH : ST_RD_REQ;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = (st != ST_IDLE) && (st != ST_FINISH);
        done      = (st == ST_FINISH);
        buf_rd    = (st == ST_FETCH);
        req_valid = 1'b0;
        kind      = K_LD_LO;
        cmd_idx   = idx;
        cmd_data  = word_q[7:0];
        unique case (st)
            ST_LO_REQ: begin
                req_valid = 1'b1;
                kind      = K_LD_LO;
            end
            ST_HI_REQ: begin
                req_valid = 1'b1;
                kind      = K_LD_HI;
                cmd_data  = word_q[15:8];
            end
            ST_WR_REQ: begin
                req_valid = 1'b1;
                kind      = K_WR;
            end
            ST_RD_REQ: begin
                req_valid = 1'b1;
                kind      = K_RD;
                cmd_idx   = poll_idx;
            end
            default: ;
        endcase
    end

    assign buf_idx   = idx;
    assign timer_clr = (st == ST_WR_RSP) && rsp_valid;

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            word_q   <= '0;
            page_q   <= '0;
            found    <= 1'b0;
            poll_idx <= '0;
            poll_val <= '0;
            err      <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    idx    <= '0;
                    page_q <= page_num;
                    found  <= 1'b0;
                    err    <= 1'b0;
                end
                ST_EXAM: begin
                    word_q <= buf_word;
                    if (buf_word == ERASED_WORD) begin
                        if (!last) idx <= idx + 1'b1;
                    end else if (!found) begin
                        found    <= 1'b1;
                        poll_idx <= idx;
                        poll_val <= buf_word[7:0];
                    end
                end
                ST_HI_RSP: if (rsp_valid && !last) idx <= idx + 1'b1;
                ST_RD_RSP: if (rsp_valid && rsp_byte != poll_val && expired) err <= 1'b1;
                default: ;
            endcase
        end
    end

    fpp_cmd_build #(
        .IDX_W (IDX_W),
        .PAGE_W(PAGE_W)
    ) u_build (
        .kind (kind),
        .page (page_q),
        .idx  (cmd_idx),
        .data (cmd_data),
        .cmd  (req_cmd)
    );

    fpp_wait_timer #(
        .LIMIT(WAIT_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (timer_clr),
        .expired(expired)
    );

endmodule

// File: rtl/fpp_checker.sv
module fpp_checker
    import fpp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_cmd,
    input logic        rsp_valid
);
    logic       acc;
    logic [7:0] op;
    logic       outst;
    logic       wr_pend;
    logic       lo_ok;
    logic [7:0] lo_idx;

    assign acc = req_valid && req_ready;
    assign op  = req_cmd[31:24];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst   <= 1'b0;
            wr_pend <= 1'b0;
            lo_ok   <= 1'b0;
            lo_idx  <= '0;
        end else begin
            if (acc)            outst <= 1'b1;
            else if (rsp_valid) outst <= 1'b0;
            if (acc && op == OP_WR_PAGE) wr_pend <= 1'b1;
            else if (done)               wr_pend <= 1'b0;
            if (acc && op == OP_LD_LO) begin
                lo_ok  <= 1'b1;
                lo_idx <= req_cmd[15:8];
            end else if (acc && op == OP_LD_HI) begin
                lo_ok  <= 1'b0;
            end
        end
    end

    p_hold_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_cmd));

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        outst |-> !req_valid);

    p_hi_after_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op == OP_LD_HI |-> lo_ok && req_cmd[15:8] == lo_idx);

    p_load_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (op == OP_LD_LO || op == OP_LD_HI)
            |-> req_cmd[23:16] == 8'h00 && (req_cmd[15:8] >> IDX_W) == 8'h00);

    p_only_poll_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend && req_valid |-> op == OP_RD_LO);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_err_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

endmodule

bind flash_page_prog fpp_checker #(
    .IDX_W(IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_cmd  (req_cmd),
    .rsp_valid(rsp_valid)
);

// File: tb/flash_page_prog_tb.sv
module flash_page_prog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 3;
    localparam int PAGE_W     = 7;
    localparam int WAIT_CYC   = 40;
    localparam int WORDS      = 1 << IDX_W;

    logic              clk;
    logic              rst_n;
    logic              start;
    logic [PAGE_W-1:0] page_num;
    logic              busy, done, err, buf_rd;
    logic [IDX_W-1:0]  buf_idx;
    logic [15:0]       buf_word;
    logic              req_valid, req_ready, rsp_valid;
    logic [31:0]       req_cmd;
    logic [7:0]        rsp_byte;

    flash_page_prog #(
        .IDX_W      (IDX_W),
        .PAGE_W     (PAGE_W),
        .WAIT_CYCLES(WAIT_CYC)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .page_num (page_num),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .buf_rd   (buf_rd),
        .buf_idx  (buf_idx),
        .buf_word (buf_word),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_cmd  (req_cmd),
        .rsp_valid(rsp_valid),
        .rsp_byte (rsp_byte)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem [WORDS];
    logic [31:0] log_q [256];
    int          n_log = 0;
    logic [31:0] cur = '0;
    int          lat = 0;
    bit          pend = 0;
    int          flash_busy = 0;
    int          busy_len = 10;
    int          cyc = 0;
    int          wr_rsp_cyc = 0;
    int          viol_out = 0;
    int          viol_hold = 0;
    int          viol_done = 0;
    bit          held = 0;
    logic [31:0] prev_cmd = '0;
    bit          prev_done = 0;

    // Page buffer: one-cycle read latency
    always @(posedge clk) if (buf_rd) buf_word <= mem[buf_idx];

    // Shifter and target flash model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            req_ready  <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_byte   <= 8'h00;
            pend       <= 0;
            flash_busy <= 0;
        end else begin
            rsp_valid <= 1'b0;
            if (flash_busy > 0) flash_busy <= flash_busy - 1;
            if (req_valid && req_ready) begin
                if (n_log < 256) log_q[n_log] <= req_cmd;
                n_log     <= n_log + 1;
                cur       <= req_cmd;
                req_ready <= 1'b0;
                pend      <= 1;
                lat       <= 2;
                if (req_cmd[31:24] == 8'h4C) flash_busy <= busy_len;
            end else if (req_valid && !pend) begin
                req_ready <= 1'b1;
            end
            if (pend) begin
                if (lat == 0) begin
                    rsp_valid <= 1'b1;
                    pend      <= 0;
                    if (cur[31:24] == 8'h20)
                        rsp_byte <= (flash_busy > 0) ? 8'hFF : mem[cur[8 +: IDX_W]][7:0];
                    else
                        rsp_byte <= 8'h00;
                end else begin
                    lat <= lat - 1;
                end
            end
        end
    end

    // Port monitors, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid && cur[31:24] == 8'h4C) wr_rsp_cyc = cyc;
            if (req_valid && pend) viol_out++;
            if (held && (!req_valid || req_cmd != prev_cmd)) viol_hold++;
            if ((done && busy) || (done && prev_done)) viol_done++;
        end
        held      = req_valid && !req_ready;
        prev_cmd  = req_cmd;
        prev_done = done;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_page(input logic [PAGE_W-1:0] pg, input int blen, input bit extra,
                            output bit e, output int base, output int dly,
                            output int to_done, output bit err_after);
        int k;
        busy_len   = blen;
        base       = n_log;
        wr_rsp_cyc = 0;
        @(negedge clk);
        page_num = pg;
        start    = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        err_after = err;
        chk(busy === 1'b1, "R2 busy after start", 32'(busy), 32'd1);
        if (extra) begin
            repeat (5) @(negedge clk);
            page_num = pg + 1'b1;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (k = 0; k < 3000 && !done; k++) @(negedge clk);
        if (!done) chk(1'b0, "R11 run never signalled done", 32'd0, 32'd1);
        e       = err;
        dly     = cyc - wr_rsp_cyc;
        to_done = k;
        @(negedge clk);
    endtask

    // Compares the log against the expected loads and write; counts poll reads after them
    task automatic check_log(input logic [PAGE_W-1:0] pg, input int base, output int nr);
        logic [31:0] exp_q [2*WORDS + 1];
        logic [15:0] a16;
        int ne = 0;
        int pidx = -1;
        for (int i = 0; i < WORDS; i++) begin
            if (mem[i] != 16'hFFFF) begin
                if (pidx < 0) pidx = i;
                exp_q[ne] = {8'h40, 8'h00, 8'(i), mem[i][7:0]};
                ne++;
                exp_q[ne] = {8'h48, 8'h00, 8'(i), mem[i][15:8]};
                ne++;
            end
        end
        if (ne > 0) begin
            a16 = 16'({pg, 3'b000});
            exp_q[ne] = {8'h4C, a16, 8'h00};
            ne++;
        end
        chk(n_log - base >= ne, "R3 instruction count", 32'(n_log - base), 32'(ne));
        for (int j = 0; j < ne; j++) begin
            if (j == ne - 1)
                chk(log_q[base + j] == exp_q[j], "R5 page write", log_q[base + j], exp_q[j]);
            else
                chk(log_q[base + j] == exp_q[j], "R3 byte load", log_q[base + j], exp_q[j]);
        end
        nr = n_log - base - ne;
        if (pidx >= 0) begin
            a16 = 16'({pg, 3'(pidx)});
            for (int j = 0; j < nr; j++)
                chk(log_q[base + ne + j] == {8'h20, a16, 8'h00}, "R9 poll read only",
                    log_q[base + ne + j], {8'h20, a16, 8'h00});
        end
    endtask

    task automatic t_reset();
        rst_n    = 1'b0;
        start    = 1'b0;
        page_num = '0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", {busy, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(err == 1'b0, "R1 err after reset", 32'(err), 32'd0);
        chk(req_valid == 1'b0, "R1 req_valid after reset", 32'(req_valid), 32'd0);
        chk(buf_rd == 1'b0 && busy == 1'b0, "R1 buf_rd/busy after reset", {buf_rd, busy}, 32'd0);
    endtask

    task automatic t_poll_normal();
        bit e, ea; int base, dly, td, nr;
        mem = '{16'h1234, 16'hFFFF, 16'hA55A, 16'h00FF, 16'hFF00, 16'hFFFF, 16'h0001, 16'h8000};
        run_page(7'h35, 12, 1'b0, e, base, dly, td, ea);
        check_log(7'h35, base, nr);
        chk(nr >= 1, "R6 polling reads issued", 32'(nr), 32'd1);
        chk(e == 1'b0, "R6 err after matched poll", 32'(e), 32'd0);
    endtask

    task automatic t_all_erased();
        bit e, ea; int base, dly, td, nr;
        for (int i = 0; i < WORDS; i++) mem[i] = 16'hFFFF;
        run_page(7'h12, 12, 1'b0, e, base, dly, td, ea);
        check_log(7'h12, base, nr);
        chk(n_log - base == 0, "R4 no instructions for erased page", 32'(n_log - base), 32'd0);
        chk(e == 1'b0, "R4 err for erased page", 32'(e), 32'd0);
        chk(td <= 2 * WORDS + 8, "R4 erased page run length", 32'(td), 32'(2 * WORDS + 8));
    endtask

    task automatic t_timed_wait();
        bit e, ea; int base, dly, td, nr;
        mem = '{16'hFFFF, 16'h56FF, 16'h1111, 16'hFFFF, 16'h2233, 16'hFFFF, 16'hFFFF, 16'h7F7F};
        run_page(7'h7F, 5, 1'b0, e, base, dly, td, ea);
        check_log(7'h7F, base, nr);
        chk(nr == 0, "R7 no poll reads on 0xFF poll byte", 32'(nr), 32'd0);
        chk(dly >= WAIT_CYC && dly <= WAIT_CYC + 4, "R7 timed wait length", 32'(dly), 32'(WAIT_CYC));
        chk(e == 1'b0, "R7 err after timed wait", 32'(e), 32'd0);
    endtask

    task automatic t_poll_timeout();
        bit e, ea; int base, dly, td, nr;
        mem = '{16'hFFFF, 16'h0102, 16'h0304, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0506};
        run_page(7'h01, 5000, 1'b0, e, base, dly, td, ea);
        check_log(7'h01, base, nr);
        chk(e == 1'b1, "R8 err on poll timeout", 32'(e), 32'd1);
        chk(nr >= 2, "R8 polling repeated before timeout", 32'(nr), 32'd2);
        chk(err == 1'b1, "R8 err held after done", 32'(err), 32'd1);
    endtask

    task automatic t_restart_ignored();
        bit e, ea; int base, dly, td, nr;
        int writes = 0;
        mem = '{16'hABCD, 16'hFFFF, 16'h1357, 16'h2468, 16'hFFFF, 16'h9999, 16'hFFFF, 16'h0F0F};
        run_page(7'h44, 12, 1'b1, e, base, dly, td, ea);
        chk(ea == 1'b0, "R8 err cleared by start", 32'(ea), 32'd0);
        check_log(7'h44, base, nr);
        for (int j = base; j < n_log; j++) if (log_q[j][31:24] == 8'h4C) writes++;
        chk(writes == 1, "R2 second start ignored", 32'(writes), 32'd1);
        chk(e == 1'b0, "R6 err after restart run", 32'(e), 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        buf_word = '0;
        t_reset();
        t_poll_normal();
        t_all_erased();
        t_timed_wait();
        t_poll_timeout();
        t_restart_ignored();
        chk(viol_out == 0, "R10 request while one outstanding", 32'(viol_out), 32'd0);
        chk(viol_hold == 0, "R10 request changed before ready", 32'(viol_hold), 32'd0);
        chk(viol_done == 0, "R11 done pulse shape", 32'(viol_done), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule